// File: doc/BRIEF.md
# Strap-Aware PHY Status Indicator Driver

This block produces the six status indicator pins of a 10/100 Ethernet PHY: link, transmit activity, receive activity, collision, duplex and speed. Five of those pins double as PHY address strap inputs. While reset is held, the block releases the shared pins so that the external pull resistors set their levels. It keeps loading those levels into a capture register. When reset ends, the captured value is frozen and becomes the PHY address.

After reset, each shared pin rests at its captured strap level when its status is inactive. It drives the opposite level when its status is active, so an indicator wired against the strap lights correctly whichever way the pin was strapped. The duplex pin has a mode input that selects between this strap-adjusted polarity and plain active-high polarity. The speed pin is not shared and is always active-high. Transmit and receive activity are stretched to a minimum on-time so that short frames still give a visible pulse. The collision indicator is suppressed in full duplex.

Top module: `phy_led_strap`

## Requirements
- R1: `phy_addr` equals `strap_in` as sampled on the last rising edge at which `rst` was high. It does not change while `rst` stays low. Bit 0 is the link pin, bit 1 transmit, bit 2 receive, bit 3 collision and bit 4 duplex.
- R2: On the edge after any edge with `rst` high, `pin_oe` is 5'b00000 and all six indicator outputs are 0. After the first edge with `rst` low, `pin_oe` is 5'b11111.
- R3: One cycle after a sample with `rst` low, `lnk_o` equals `phy_addr[0]` XOR `link_up`.
- R4: `tx_o` equals `phy_addr[1]` XOR the stretched transmit activity, one cycle after the sample. The stretched activity is 1 if `tx_act` was high at the current sample or at any of the previous HOLD samples taken with `rst` low. `rx_o` follows the same rule with `rx_act` and `phy_addr[2]`.
- R5: One cycle after a sample, `col_o` equals `phy_addr[3]` XOR (`col_act` AND NOT `full_dpx`). In full duplex the pin sits at its strap level.
- R6: With `dpx_adapt` high, `dpx_o` equals `phy_addr[4]` XOR `full_dpx`, one cycle after the sample.
- R7: With `dpx_adapt` low, `dpx_o` equals `full_dpx`, one cycle after the sample, whatever the strap.
- R8: `spd_o` equals `spd_100` one cycle after the sample (1 means 100 Mb/s). It has no strap adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap capture window |
| strap_in | input | 5 | Levels on the five shared pins while released |
| link_up | input | 1 | Link established |
| tx_act | input | 1 | Transmit activity |
| rx_act | input | 1 | Receive activity |
| col_act | input | 1 | Collision activity |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dpx | input | 1 | 1 = full duplex |
| dpx_adapt | input | 1 | 1 = duplex pin uses strap-adjusted polarity |
| lnk_o | output | 1 | Link pin drive level |
| tx_o | output | 1 | Transmit pin drive level |
| rx_o | output | 1 | Receive pin drive level |
| col_o | output | 1 | Collision pin drive level |
| dpx_o | output | 1 | Duplex pin drive level |
| spd_o | output | 1 | Speed pin drive level |
| pin_oe | output | 5 | Output enables of the shared pins, same bit order as `phy_addr` |
| phy_addr | output | 5 | Captured strap address |

## Verification
All outputs are registered. Every status result is therefore due one clock after the sample that caused it, and the address is due one clock after the last sample taken in reset. The bench model updates on each rising edge from the inputs driven at the previous falling edge. It compares all outputs at the next falling edge, before new inputs are applied, so every comparison lands exactly one register stage after its cause. For the stretched activity pins, the model counts the samples since the last active one and expects the pin to stay active for HOLD further cycles. Short pulses are checked against that count.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
  localparam int unsigned NUM_SHARED = 5;
  localparam int unsigned IDX_LINK   = 0;
  localparam int unsigned IDX_TX     = 1;
  localparam int unsigned IDX_RX     = 2;
  localparam int unsigned IDX_COL    = 3;
  localparam int unsigned IDX_DPX    = 4;
  typedef logic [NUM_SHARED-1:0] shared_vec_t;
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] strap_in,
  output logic [W-1:0] captured
);
  always_ff @(posedge clk) begin
    if (rst) captured <= strap_in;
  end

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(captured)); // R1
endmodule

// File: rtl/act_stretch.sv
module act_stretch #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic act_in,
  output logic act_out
);
  generate
    if (HOLD == 0) begin : g_pass
      assign act_out = act_in;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(HOLD + 1);
      localparam logic [CW-1:0] LOAD = CW'(HOLD);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (act_in)      cnt <= LOAD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
      end
      assign act_out = act_in | (cnt != '0);

      AST_STRETCH_HELD: assert property (@(posedge clk) disable iff (rst)
        act_in |=> act_out); // R4
    end
  endgenerate
endmodule

// File: rtl/pin_polarity.sv
module pin_polarity #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] strap,
  input  logic [W-1:0] active,
  input  logic [W-1:0] fixed_high,
  output logic [W-1:0] level
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign level[i] = fixed_high[i] ? active[i] : (strap[i] ^ active[i]);
  end
endmodule

// File: rtl/phy_led_strap.sv
module phy_led_strap
  import phy_led_pkg::*;
#(
  parameter int unsigned HOLD = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SHARED-1:0] strap_in,
  input  logic                  link_up,
  input  logic                  tx_act,
  input  logic                  rx_act,
  input  logic                  col_act,
  input  logic                  spd_100,
  input  logic                  full_dpx,
  input  logic                  dpx_adapt,
  output logic                  lnk_o,
  output logic                  tx_o,
  output logic                  rx_o,
  output logic                  col_o,
  output logic                  dpx_o,
  output logic                  spd_o,
  output logic [NUM_SHARED-1:0] pin_oe,
  output logic [NUM_SHARED-1:0] phy_addr
);
  localparam int unsigned N_ACT = 2;

  shared_vec_t cap;
  shared_vec_t act_vec;
  shared_vec_t fix_vec;
  shared_vec_t lvl;
  logic [N_ACT-1:0] raw_act;
  logic [N_ACT-1:0] str_act;

  strap_latch #(.W(NUM_SHARED)) u_latch (
    .clk(clk), .rst(rst), .strap_in(strap_in), .captured(cap)
  );

  assign raw_act = {rx_act, tx_act};

  for (genvar k = 0; k < N_ACT; k++) begin : g_str
    act_stretch #(.HOLD(HOLD)) u_str (
      .clk(clk), .rst(rst), .act_in(raw_act[k]), .act_out(str_act[k])
    );
  end

  always_comb begin
    act_vec           = '0;
    act_vec[IDX_LINK] = link_up;
    act_vec[IDX_TX]   = str_act[0];
    act_vec[IDX_RX]   = str_act[1];
    act_vec[IDX_COL]  = col_act & ~full_dpx;
    act_vec[IDX_DPX]  = full_dpx;
    fix_vec           = '0;
    fix_vec[IDX_DPX]  = ~dpx_adapt;
  end

  pin_polarity #(.W(NUM_SHARED)) u_pol (
    .strap(cap), .active(act_vec), .fixed_high(fix_vec), .level(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe <= '0;
      lnk_o  <= 1'b0;
      tx_o   <= 1'b0;
      rx_o   <= 1'b0;
      col_o  <= 1'b0;
      dpx_o  <= 1'b0;
      spd_o  <= 1'b0;
    end else begin
      pin_oe <= '1;
      lnk_o  <= lvl[IDX_LINK];
      tx_o   <= lvl[IDX_TX];
      rx_o   <= lvl[IDX_RX];
      col_o  <= lvl[IDX_COL];
      dpx_o  <= lvl[IDX_DPX];
      spd_o  <= spd_100;
    end
  end

  assign phy_addr = cap;

  AST_OE_RELEASED: assert property (@(posedge clk)
    rst |=> (pin_oe == '0)); // R2
  AST_COL_QUIET_FD: assert property (@(posedge clk) disable iff (rst)
    full_dpx |=> (col_o == phy_addr[IDX_COL])); // R5
  AST_DPX_FIXED: assert property (@(posedge clk) disable iff (rst)
    !dpx_adapt |=> (dpx_o == $past(full_dpx))); // R7
  AST_SPD_PLAIN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (spd_o == $past(spd_100))); // R8
endmodule

// File: tb/test_phy_led_strap.sv
module test_phy_led_strap;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int FAR = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] strap_in = 5'b00011;
  logic link_up = 0, tx_act = 0, rx_act = 0, col_act = 0;
  logic spd_100 = 0, full_dpx = 0, dpx_adapt = 1;
  logic lnk_o, tx_o, rx_o, col_o, dpx_o, spd_o;
  logic [4:0] pin_oe, phy_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // reference model state
  logic [4:0] m_cap = '0;
  logic [4:0] m_oe = '0;
  logic m_lnk = 0, m_tx = 0, m_rx = 0, m_col = 0, m_dpx = 0, m_spd = 0;
  int since_tx = FAR;
  int since_rx = FAR;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_led_strap #(.HOLD(HOLD)) i_phy_led_strap (
    .clk(clk), .rst(rst), .strap_in(strap_in),
    .link_up(link_up), .tx_act(tx_act), .rx_act(rx_act), .col_act(col_act),
    .spd_100(spd_100), .full_dpx(full_dpx), .dpx_adapt(dpx_adapt),
    .lnk_o(lnk_o), .tx_o(tx_o), .rx_o(rx_o), .col_o(col_o),
    .dpx_o(dpx_o), .spd_o(spd_o), .pin_oe(pin_oe), .phy_addr(phy_addr)
  );

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cap = strap_in;
      m_oe = 5'b00000;
      {m_lnk, m_tx, m_rx, m_col, m_dpx, m_spd} = '0;
      since_tx = FAR;
      since_rx = FAR;
    end else begin
      if (tx_act) since_tx = 0; else if (since_tx < FAR) since_tx++;
      if (rx_act) since_rx = 0; else if (since_rx < FAR) since_rx++;
      m_oe  = 5'b11111;
      m_lnk = m_cap[0] ^ link_up;
      m_tx  = m_cap[1] ^ (since_tx <= HOLD);
      m_rx  = m_cap[2] ^ (since_rx <= HOLD);
      m_col = m_cap[3] ^ (col_act & ~full_dpx);
      m_dpx = dpx_adapt ? (m_cap[4] ^ full_dpx) : full_dpx;
      m_spd = spd_100;
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 phy_addr", phy_addr, m_cap);
    chk("R2 pin_oe", pin_oe, m_oe);
    chk("R3 lnk_o", {4'b0, lnk_o}, {4'b0, m_lnk});
    chk("R4 tx_o", {4'b0, tx_o}, {4'b0, m_tx});
    chk("R4 rx_o", {4'b0, rx_o}, {4'b0, m_rx});
    chk("R5 col_o", {4'b0, col_o}, {4'b0, m_col});
    chk(dpx_adapt ? "R6 dpx_o" : "R7 dpx_o", {4'b0, dpx_o}, {4'b0, m_dpx});
    chk("R8 spd_o", {4'b0, spd_o}, {4'b0, m_spd});
  endtask

  // sparse: activity pulses rare (stretch visible); dense otherwise
  task automatic run(input int n, input bit sparse, input bit fd_only);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      link_up  = $urandom % 2;
      tx_act   = sparse ? (($urandom % 9) == 0) : ($urandom % 2);
      rx_act   = sparse ? (($urandom % 11) == 0) : ($urandom % 2);
      col_act  = $urandom % 2;
      spd_100  = $urandom % 2;
      full_dpx = fd_only ? 1'b1 : ($urandom % 2);
      if (($urandom % 16) == 0) dpx_adapt = ~dpx_adapt;
    end
  endtask

  task automatic do_reset(input logic [4:0] s1, input logic [4:0] s2);
    @(negedge clk);
    rst = 1'b1;
    strap_in = s1;
    @(negedge clk);
    compare_all();          // R2 outputs released during reset
    strap_in = s2;          // R1 last sample in reset wins
    @(negedge clk);
    compare_all();
    rst = 1'b0;
    strap_in = ~s2;         // R1 changes after reset must be ignored
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset(5'b10101, 5'b00011);
    run(300, 1'b1, 1'b0);
    run(300, 1'b0, 1'b0);
    run(60, 1'b0, 1'b1);    // R5 full duplex only
    dpx_adapt = 1'b0;
    do_reset(5'b00000, 5'b11100);
    run(400, 1'b1, 1'b0);
    do_reset(5'b11111, 5'b11111);
    run(300, 1'b1, 1'b0);
    do_reset(5'b00000, 5'b01010);
    tx_act = 1'b1;          // R4 single-cycle pulse then quiet
    @(negedge clk);
    compare_all();
    tx_act = 1'b0;
    repeat (HOLD + 3) begin
      @(negedge clk);
      compare_all();
    end
    run(300, 1'b0, 1'b0);
    @(negedge clk);
    compare_all();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule